// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a two-wire serial bus slave that holds a small bank of control bytes: per-output enables, a frequency select, a test enable and spread-spectrum settings, for example. The bus clock and data lines are oversampled on a fast system clock. The slave pulls the data line low through an output-enable pin, which gives open-drain behaviour. The whole bank is presented to the rest of the chip as one flat parallel bus.

The block has no register pointer. A write transaction is laid out as follows: first the address byte, then a command byte and a count byte, both of which are acknowledged and then discarded, and then the data bytes. The data bytes always fill the bank starting at byte 0. To change a later byte, a host must resend every byte before it. A read transaction begins streaming the bank from byte 0 as soon as the address acknowledge ends. It continues until the master stops acknowledging or ends the transfer.

Top module: `ctl_reg_slave`

## Requirements
- R1: After reset, every register byte reads 0xFF on `regs_o` and `sda_oe` is low.
- R2: A start condition (data falls while clock is high) begins a new address phase at any time, including a repeated start during a transfer. A stop condition (data rises while clock is high) releases the data line and ends the transfer.
- R3: The first byte after a start is a 7-bit address followed by a read/write bit in its LSB. Only 0xD2 (write) and 0xD3 (read) are acknowledged. For any other address the slave drives nothing for the rest of the transfer and leaves every register unchanged.
- R4: In a write, the first two bytes after the address are acknowledged and have no effect on the registers.
- R5: In a write, the data bytes are received MSB first. Data byte k is stored in register k, which appears at `regs_o[8k+7:8k]`. Each data byte is acknowledged by driving the data line low for the ninth clock, and the register takes its value at that acknowledge.
- R6: A write accepts at most NREG (10) data bytes. Any further bytes are not acknowledged and are discarded.
- R7: A write of k data bytes changes only registers 0 to k-1. All other registers keep their values.
- R8: After acknowledging 0xD3, the slave sends register 0, MSB first, then registers 1, 2 and so on, wrapping from register NREG-1 back to register 0.
- R9: During a read, when the master does not acknowledge a byte, the slave releases the data line and drives nothing more until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| regs_o | output | NREG*8 | Register bank, byte k at bits 8k+7:8k |

## Verification
A bus-level master in the bench drives writes with random lengths between 1 and 12 data bytes. Short writes show whether untouched registers keep their values. Writes longer than the bank show where acknowledges stop and whether bytes past the end are dropped. Reads of random length, some longer than the bank, compare the stream with a model and check both the start at register 0 and the wrap. Foreign addresses, a repeated start in the middle of a write, and extra clocks after a refused read acknowledge check that the slave stays silent and forgets a half-finished transaction.

// File: rtl/ctl_reg_slave.sv
module ctl_reg_slave #(
  parameter int         NREG     = 10,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] RST_BYTE = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = $clog2(NREG + 4);
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK} st_t;

  logic [2:0] scl_q, sda_q;
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c, in_idle;
  st_t state;
  logic [3:0] bcnt;
  logic [7:0] sh;
  logic [IW-1:0] idx, dsel;
  logic rd, ack_go;
  logic [PW-1:0] ptr;
  logic [7:0] regs [NREG];

  assign scl_s    = scl_q[1];
  assign sda_s    = sda_q[1];
  assign scl_rise = scl_s & ~scl_q[2];
  assign scl_fall = ~scl_s & scl_q[2];
  assign start_c  = scl_s & scl_q[2] & sda_q[2] & ~sda_s;
  assign stop_c   = scl_s & scl_q[2] & ~sda_q[2] & sda_s;
  assign in_idle  = (state == S_IDLE);
  assign dsel     = idx - IW'(3);

  always_comb begin
    if (idx == '0)          ack_go = (sh[7:1] == DEV_ADDR);
    else if (idx < IW'(3))  ack_go = 1'b1;
    else                    ack_go = (dsel < IW'(NREG));
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bcnt   <= '0;
      sh     <= '0;
      idx    <= '0;
      rd     <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= RST_BYTE;
    end else if (start_c) begin
      state  <= S_RX;
      bcnt   <= '0;
      idx    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise && bcnt != 4'd8) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            if (ack_go) begin
              sda_oe <= 1'b1;
              state  <= S_RX_ACK;
              idx    <= idx + IW'(1);
              if (idx == '0) rd <= sh[0];
              if (idx >= IW'(3)) regs[PW'(dsel)] <= sh;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_RX_ACK: begin
          if (scl_fall) begin
            bcnt <= '0;
            if (rd) begin
              state  <= S_TX;
              ptr    <= '0;
              sh     <= regs[0];
              sda_oe <= ~regs[0][7];
            end else begin
              state  <= S_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bcnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= S_TX_ACK;
              ptr    <= (ptr == PW'(NREG - 1)) ? '0 : ptr + PW'(1);
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
              bcnt   <= bcnt + 4'd1;
            end
          end
        end
        S_TX_ACK: begin
          if (scl_rise && sda_s) begin
            state <= S_IDLE;
          end else if (scl_fall) begin
            sh     <= regs[ptr];
            sda_oe <= ~regs[ptr][7];
            bcnt   <= '0;
            state  <= S_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctl_reg_slave_chk.sv
module ctl_reg_slave_chk #(
  parameter int W = 80
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_s,
  input logic         start_c,
  input logic         stop_c,
  input logic         in_idle,
  input logic         sda_oe,
  input logic [W-1:0] regs_o
);
  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && in_idle));

  p_start_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (!sda_oe && !in_idle));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  p_commit_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> sda_oe);

  p_drive_when_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind ctl_reg_slave ctl_reg_slave_chk #(.W(NREG * 8)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(start_c),
  .stop_c(stop_c), .in_idle(in_idle), .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/tb_ctl_reg_slave.sv
module tb_ctl_reg_slave;
  localparam int NREG = 10;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  logic sda_line;
  logic [7:0] model [NREG];
  int checks = 0, errors = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  ctl_reg_slave #(.NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b = sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~give_ack);
  endtask

  function automatic int reg_mismatch(input logic [NREG*8-1:0] r);
    int m = 0;
    for (int i = 0; i < NREG; i++) if (r[i*8 +: 8] != model[i]) m++;
    return m;
  endfunction

  function automatic logic exp_data_ack(input int i);
    return i < NREG;
  endfunction

  task automatic do_write(input int n);
    logic a;
    logic [7:0] d;
    int miss = 0;
    bus_start;
    send_byte(8'hD2, a);     chk("R3 write address 0xD2 acknowledged", a, 1);
    send_byte($urandom, a);  chk("R4 command byte acknowledged", a, 1);
    send_byte($urandom, a);  chk("R4 count byte acknowledged", a, 1);
    for (int i = 0; i < n; i++) begin
      d = $urandom;
      send_byte(d, a);
      if (a != exp_data_ack(i)) miss++;
      if (i < NREG) model[i] = d;
    end
    bus_stop;
    chk("R6 data acknowledge pattern", miss, 0);
    chk("R5 R7 R4 register bank after write", reg_mismatch(regs_o), 0);
  endtask

  task automatic do_read(input int n);
    logic a;
    logic [7:0] d;
    int miss = 0, low = 0;
    bus_start;
    send_byte(8'hD3, a);  chk("R3 read address 0xD3 acknowledged", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      if (d != model[i % NREG]) miss++;
    end
    chk("R8 read stream from register 0 with wrap", miss, 0);
    for (int i = 0; i < 9; i++) begin
      bit_in(a);
      if (!a) low++;
    end
    chk("R9 silent after master NACK", low, 0);
    bus_stop;
  endtask

  task automatic do_foreign(input logic [7:0] addr);
    logic a;
    int acks = 0;
    bus_start;
    send_byte(addr, a);
    chk("R3 foreign address not acknowledged", a, 0);
    for (int i = 0; i < 3; i++) begin
      send_byte($urandom, a);
      if (a) acks++;
    end
    bus_stop;
    chk("R3 no acknowledge after foreign address", acks, 0);
    chk("R3 registers kept after foreign address", reg_mismatch(regs_o), 0);
  endtask

  task automatic do_restart;
    logic a;
    logic [7:0] d;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h5A, a);
    model[0] = 8'h5A;
    bus_start;
    send_byte(8'hD2, a);     chk("R2 address after repeated start acknowledged", a, 1);
    send_byte(8'h33, a);
    send_byte(8'h44, a);
    for (int i = 0; i < 2; i++) begin
      d = 8'hC0 + 8'(i);
      send_byte(d, a);
      model[i] = d;
    end
    bus_stop;
    chk("R2 repeated start refills from register 0", reg_mismatch(regs_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] fa;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
    w(5);
    rst_n = 1'b1;
    w(3);
    chk("R1 reset register values", reg_mismatch(regs_o), 0);
    chk("R1 reset data line released", int'(sda_oe), 0);
    do_read(3);
    do_write(3);
    do_write(NREG);
    do_write(NREG + 2);
    do_write(2);
    do_read(NREG + 3);
    do_foreign(8'hA4);
    do_foreign(8'hD4);
    do_restart;
    for (int it = 0; it < 14; it++) begin
      case ($urandom_range(0, 2))
        0: do_write($urandom_range(1, NREG + 2));
        1: do_read($urandom_range(1, NREG + 2));
        default: begin
          fa = $urandom;
          if (fa[7:1] == 7'h69) fa[7] = ~fa[7];
          do_foreign(fa);
        end
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule